// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial channel with no start or stop bits. It sends one 8-bit frame on `txd` and, at the same time, takes one 8-bit frame in on `rxd`. Both lines follow a shift clock, `serClk`, that the block derives from the system clock with a fixed divider. The clock runs only while a frame is in flight and rests high otherwise. Bits go least significant first. The block changes a transmit bit when `serClk` falls and samples a receive bit when `serClk` rises.

Software reaches the block over a small register bus with four word addresses: control, transmit data, receive data and status. The status register carries a transmit-empty flag, a receive-full flag and an overrun flag. When the transmit-empty or receive-full flag goes from 0 to 1, the block raises a one-cycle interrupt request. A transfer engine can move data without software through two strobes. Its write of transmit data clears transmit-empty, and its read of receive data clears receive-full. An overrun stops the channel in both directions until software clears the flag.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 and status (address 3) reads 0x01, with bit 0 transmit-empty, bit 1 receive-full and bit 2 overrun. `txd` and `serClk` are 1. In control, bit 0 enables transmit and bit 1 enables receive. Address 1 holds transmit data and address 2 holds receive data.
- R2: A control write that would set both enable bits while exactly one is set leaves control unchanged. From 0x00, a single write of 0x03 enables both directions.
- R3: A frame starts when transmit is enabled and transmit-empty is 0. At that point the data register is copied to the shifter, transmit-empty returns to 1 and `txIrq` pulses for one cycle. `txd` carries the byte LSB first and changes on each falling edge of `serClk`. Each half period of `serClk` lasts HALF_DIV system clocks.
- R4: When receive is enabled, `rxd` is sampled on each rising edge of `serClk`, LSB first. After the eighth bit the byte moves to the receive data register, receive-full rises and `rxIrq` pulses for one cycle.
- R5: If new data is written and transmit-empty is cleared before the current frame ends, the next frame follows with no idle `serClk` time. Otherwise `serClk` stops high after the frame.
- R6: A frame that ends while receive-full is 1 sets overrun. The receive data register keeps its earlier byte and the new frame is discarded.
- R7: While overrun is 1, no frame starts in either direction, even after receive-full is cleared, and `serClk` stays high.
- R8: Software clears a status flag only by writing 0 to it after a status read that returned it as 1. Writing 1 to a flag, or writing 0 without that prior read, leaves the flag unchanged.
- R9: A pulse on `dmaTxWr` loads `dmaTxData` and clears transmit-empty. A pulse on `dmaRxRd` clears receive-full. `dmaRxData` always shows the receive data register.
- R10: A control write that changes the enables stops any frame at once: `serClk` returns high. `txd` is 1 whenever transmit is disabled or no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busRd | input | 1 | Register read strobe |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Register write data |
| busRdata | output | 8 | Register read data |
| dmaTxWr | input | 1 | Transfer engine write of transmit data |
| dmaTxData | input | 8 | Transfer engine transmit byte |
| dmaRxRd | input | 1 | Transfer engine read of receive data |
| dmaRxData | output | 8 | Receive data register contents |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| serClk | output | 1 | Shift clock |
| txIrq | output | 1 | Transmit-empty interrupt pulse |
| rxIrq | output | 1 | Receive-full interrupt pulse |

## Verification
The hardest case to reach from the ports is an overrun, together with the check that software cannot clear it by a plain write. The stimulus gets there in receive-only mode. It leaves the first frame's receive-full flag set while the serial peer keeps sending, so the second frame lands on a full register. The bench makes no status read before it tries a bare write of 0 to the overrun flag. Only then does it read status, clear receive-full through the transfer strobe and observe that the channel stays frozen until the flag is properly cleared.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_TXD  = 2'd1;
  localparam logic [1:0] ADDR_RXD  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  // status bit positions
  localparam int ST_TXE = 0;
  localparam int ST_RXF = 1;
  localparam int ST_OVR = 2;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;    // copy tx data into shifter, start a frame
    logic shift;   // falling serial edge inside a frame
    logic sample;  // rising serial edge
    logic done;    // last bit finished
    logic busy;    // a frame is in flight
  } ssxStrobe_t;

  // state reported by the datapath to the sequencer
  typedef struct packed {
    logic txEn;
    logic rxEn;
    logic txEmpty;
    logic rxFull;
    logic overrun;
    logic enChange;  // accepted control write alters the enables this cycle
  } ssxFlags_t;
endpackage

// File: rtl/ssx_ctrl.sv
module ssx_ctrl
  import ssx_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  ssxFlags_t  flags,
  output ssxStrobe_t stb,
  output logic       serClk
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = (FRAME_BITS > 1) ? $clog2(FRAME_BITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(FRAME_BITS - 1);

  logic          active;
  logic          serClkQ;
  logic [CW-1:0] halfCnt;
  logic [BW-1:0] bitIdx;
  logic          canStart;
  logic          halfEnd;
  logic          startNow;

  always_comb begin
    canStart = !flags.overrun &&
               ((flags.txEn && !flags.txEmpty) || (flags.rxEn && !flags.txEn));
    halfEnd  = active && (halfCnt == CNT_LAST);
    startNow = 1'b0;
    stb      = '0;
    stb.busy = active;
    if (!flags.enChange) begin
      if (!active) begin
        startNow = canStart;
      end else if (halfEnd) begin
        if (!serClkQ) begin
          stb.sample = 1'b1;
        end else if (bitIdx == BIT_LAST) begin
          stb.done = 1'b1;
          // a frame landing on a full receiver overruns: do not continue
          startNow = canStart && !(flags.rxEn && flags.rxFull);
        end else begin
          stb.shift = 1'b1;
        end
      end
    end
    stb.load = startNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      serClkQ <= 1'b1;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (flags.enChange) begin
      active  <= 1'b0;
      serClkQ <= 1'b1;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (startNow) begin
      active  <= 1'b1;
      serClkQ <= 1'b0;
      halfCnt <= '0;
      bitIdx  <= '0;
    end else if (active) begin
      if (halfEnd) begin
        halfCnt <= '0;
        if (!serClkQ) begin
          serClkQ <= 1'b1;
        end else if (bitIdx == BIT_LAST) begin
          active <= 1'b0;
        end else begin
          serClkQ <= 1'b0;
          bitIdx  <= bitIdx + 1'b1;
        end
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
    end
  end

  assign serClk = serClkQ;
endmodule

// File: rtl/ssx_datapath.sv
module ssx_datapath
  import ssx_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [1:0]            busAddr,
  input  logic [FRAME_BITS-1:0] busWdata,
  output logic [FRAME_BITS-1:0] busRdata,
  input  logic                  dmaTxWr,
  input  logic [FRAME_BITS-1:0] dmaTxData,
  input  logic                  dmaRxRd,
  output logic [FRAME_BITS-1:0] dmaRxData,
  input  logic                  rxd,
  output logic                  txd,
  output logic                  txIrq,
  output logic                  rxIrq,
  input  ssxStrobe_t            stb,
  output ssxFlags_t             flags
);
  logic                  txEn, rxEn;
  logic [FRAME_BITS-1:0] txData, rxData, txShift, rxShift;
  logic                  txEmpty, rxFull, overrun;
  logic                  armTx, armRx, armOvr;
  logic                  txEmptyPrev, rxFullPrev;

  logic ctrlWr, txdWr, statWr, statRd;
  logic newTx, newRx, badPair, ctrlAccept, enChange;
  logic frameEnd;

  always_comb begin
    ctrlWr     = busWr && (busAddr == ADDR_CTRL);
    txdWr      = busWr && (busAddr == ADDR_TXD);
    statWr     = busWr && (busAddr == ADDR_STAT);
    statRd     = busRd && (busAddr == ADDR_STAT);
    newTx      = busWdata[0];
    newRx      = busWdata[1];
    // both enables may only be raised together from the all-off state
    badPair    = newTx && newRx && (txEn ^ rxEn);
    ctrlAccept = ctrlWr && !badPair;
    enChange   = ctrlAccept && ({newRx, newTx} != {rxEn, txEn});
    frameEnd   = stb.done && rxEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEn <= 1'b0;
      rxEn <= 1'b0;
    end else if (ctrlAccept) begin
      txEn <= newTx;
      rxEn <= newRx;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txData <= '0;
    end else if (dmaTxWr) begin
      txData <= dmaTxData;
    end else if (txdWr) begin
      txData <= busWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
    end else if (stb.load && txEn) begin
      txShift <= txData;
    end else if (stb.shift) begin
      txShift <= {1'b1, txShift[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (stb.sample && rxEn) begin
      rxShift <= {rxd, rxShift[FRAME_BITS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData <= '0;
    end else if (frameEnd && !rxFull) begin
      rxData <= rxShift;
    end
  end

  // flags: hardware set wins over any clear request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
      overrun <= 1'b0;
    end else begin
      if (stb.load && txEn)                              txEmpty <= 1'b1;
      else if (dmaTxWr)                                  txEmpty <= 1'b0;
      else if (statWr && armTx && !busWdata[ST_TXE])     txEmpty <= 1'b0;

      if (frameEnd && !rxFull)                           rxFull <= 1'b1;
      else if (dmaRxRd)                                  rxFull <= 1'b0;
      else if (statWr && armRx && !busWdata[ST_RXF])     rxFull <= 1'b0;

      if (frameEnd && rxFull)                            overrun <= 1'b1;
      else if (statWr && armOvr && !busWdata[ST_OVR])    overrun <= 1'b0;
    end
  end

  // a flag is armed for clearing once a status read has returned it as 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armTx  <= 1'b0;
      armRx  <= 1'b0;
      armOvr <= 1'b0;
    end else begin
      armTx  <= !statWr && txEmpty && (armTx  || statRd);
      armRx  <= !statWr && rxFull  && (armRx  || statRd);
      armOvr <= !statWr && overrun && (armOvr || statRd);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txEmptyPrev <= 1'b1;
      rxFullPrev  <= 1'b0;
    end else begin
      txEmptyPrev <= txEmpty;
      rxFullPrev  <= rxFull;
    end
  end

  always_comb begin
    case (busAddr)
      ADDR_CTRL: busRdata = FRAME_BITS'({rxEn, txEn});
      ADDR_TXD:  busRdata = txData;
      ADDR_RXD:  busRdata = rxData;
      default:   busRdata = FRAME_BITS'({overrun, rxFull, txEmpty});
    endcase
  end

  assign dmaRxData = rxData;
  assign txd       = (stb.busy && txEn) ? txShift[0] : 1'b1;
  assign txIrq     = txEmpty && !txEmptyPrev;
  assign rxIrq     = rxFull && !rxFullPrev;

  assign flags.txEn     = txEn;
  assign flags.rxEn     = rxEn;
  assign flags.txEmpty  = txEmpty;
  assign flags.rxFull   = rxFull;
  assign flags.overrun  = overrun;
  assign flags.enChange = enChange;
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int FRAME_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busRd,
  input  logic                  busWr,
  input  logic [1:0]            busAddr,
  input  logic [FRAME_BITS-1:0] busWdata,
  output logic [FRAME_BITS-1:0] busRdata,
  input  logic                  dmaTxWr,
  input  logic [FRAME_BITS-1:0] dmaTxData,
  input  logic                  dmaRxRd,
  output logic [FRAME_BITS-1:0] dmaRxData,
  input  logic                  rxd,
  output logic                  txd,
  output logic                  serClk,
  output logic                  txIrq,
  output logic                  rxIrq
);
  ssxStrobe_t stbW;
  ssxFlags_t  flagsW;

  ssx_ctrl #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) seqr (
    .clk(clk), .rstN(rstN), .flags(flagsW), .stb(stbW), .serClk(serClk)
  );

  ssx_datapath #(.FRAME_BITS(FRAME_BITS)) dpath (
    .clk(clk), .rstN(rstN),
    .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .dmaTxWr(dmaTxWr), .dmaTxData(dmaTxData),
    .dmaRxRd(dmaRxRd), .dmaRxData(dmaRxData),
    .rxd(rxd), .txd(txd), .txIrq(txIrq), .rxIrq(rxIrq),
    .stb(stbW), .flags(flagsW)
  );
endmodule

// File: rtl/ssx_checker.sv
module ssx_checker
  import ssx_pkg::*;
#(
  parameter int FRAME_BITS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  txd,
  input logic                  serClk,
  input logic                  txIrq,
  input logic                  rxIrq,
  input logic                  busWr,
  input logic [1:0]            busAddr,
  input logic [FRAME_BITS-1:0] busWdata,
  input logic [FRAME_BITS-1:0] rxDataOut,
  input ssxFlags_t             flagsW,
  input ssxStrobe_t            stbW
);
  AST_ENABLE_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    $past(flagsW.txEn ^ flagsW.rxEn) |-> !(flagsW.txEn && flagsW.rxEn)); // R2

  AST_TXIRQ_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    txIrq |-> $past(stbW.load && flagsW.txEn)); // R3

  AST_RXIRQ_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rstN)
    rxIrq |-> $past(stbW.done && flagsW.rxEn)); // R4

  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    (flagsW.overrun && $past(flagsW.overrun)) |-> $stable(rxDataOut)); // R6

  AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    flagsW.overrun |-> (serClk && !stbW.busy)); // R7

  AST_OVR_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(flagsW.overrun) && !flagsW.overrun) |->
      $past(busWr && (busAddr == ADDR_STAT) && !busWdata[ST_OVR])); // R8

  AST_TXD_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !flagsW.txEn |-> txd); // R10
endmodule

bind sync_serial_xcvr ssx_checker #(.FRAME_BITS(FRAME_BITS)) chk (
  .clk(clk), .rstN(rstN), .txd(txd), .serClk(serClk),
  .txIrq(txIrq), .rxIrq(rxIrq), .busWr(busWr), .busAddr(busAddr),
  .busWdata(busWdata), .rxDataOut(dmaRxData), .flagsW(flagsW), .stbW(stbW)
);

// File: tb/sync_serial_xcvr_test.sv
`timescale 1ns/1ps
module sync_serial_xcvr_test;
  localparam int HALF = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busRd = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0, busRdata;
  logic       dmaTxWr = 1'b0, dmaRxRd = 1'b0;
  logic [7:0] dmaTxData = '0, dmaRxData;
  logic       rxd = 1'b1, txd, serClk, txIrq, rxIrq;

  int checks = 0, failures = 0;
  int txIrqCnt = 0, rxIrqCnt = 0, frameCnt = 0;
  int peerBit = 0;
  logic [7:0] peerByte = '0, txCapSh = '0, lastTx = '0;
  logic measure = 1'b0;
  int highRun = 0, maxHigh = 0, stopFrame = 0;

  // {byte to send, byte the peer sends}
  localparam logic [15:0] VEC [0:3] = '{16'hA53C, 16'h0FF0, 16'h8001, 16'h6E91};

  sync_serial_xcvr #(.HALF_DIV(HALF)) uut (
    .clk(clk), .rstN(rstN), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dmaTxWr(dmaTxWr),
    .dmaTxData(dmaTxData), .dmaRxRd(dmaRxRd), .dmaRxData(dmaRxData),
    .rxd(rxd), .txd(txd), .serClk(serClk), .txIrq(txIrq), .rxIrq(rxIrq)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (txIrq) txIrqCnt++;
    if (rxIrq) rxIrqCnt++;
    if (measure) begin
      if (serClk) highRun++; else highRun = 0;
      if (highRun > maxHigh) maxHigh = highRun;
      if (frameCnt >= stopFrame) measure = 1'b0;
    end
  end

  // serial peer: drive on fall, capture on rise
  always @(negedge serClk) rxd = peerByte[peerBit];
  always @(posedge serClk) begin
    txCapSh = {txd, txCapSh[7:1]};
    peerBit++;
    if (peerBit == 8) begin
      peerBit = 0;
      lastTx = txCapSh;
      frameCnt++;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic waitRxFull(input string tag);
    logic [7:0] s;
    s = '0;
    for (int i = 0; i < 300 && !s[1]; i++) rdReg(2'd3, s);
    chk(tag, int'(s[1]), 1);
  endtask

  task automatic idleClocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s, d;
    int t0, r0, fc0;
    idleClocks(3);
    rstN = 1'b1;
    idleClocks(2);

    // R1 reset state
    rdReg(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rdReg(2'd3, s); chk("R1 status", s, 8'h01);
    chk("R1 txd", txd, 1); chk("R1 serClk", serClk, 1);

    // R2 enable pairing rule
    wrReg(2'd0, 8'h01); wrReg(2'd0, 8'h03);
    rdReg(2'd0, d); chk("R2 single->both refused", d, 8'h01);
    wrReg(2'd0, 8'h00); wrReg(2'd0, 8'h03);
    rdReg(2'd0, d); chk("R2 off->both accepted", d, 8'h03);

    // vector table, full duplex: R3 R4 R8
    for (int v = 0; v < 4; v++) begin
      peerByte = VEC[v][7:0]; peerBit = 0;
      t0 = txIrqCnt; r0 = rxIrqCnt;
      wrReg(2'd1, VEC[v][15:8]);
      rdReg(2'd3, s);
      wrReg(2'd3, 8'h06);
      waitRxFull("R4 rxFull rise");
      chk("R3 tx byte LSB first", lastTx, VEC[v][15:8]);
      rdReg(2'd2, d); chk("R4 rx byte", d, VEC[v][7:0]);
      chk("R3 txIrq pulse", txIrqCnt, t0 + 1);
      chk("R4 rxIrq pulse", rxIrqCnt, r0 + 1);
      wrReg(2'd3, 8'h05);
      rdReg(2'd3, s); chk("R8 clear rxFull after read", s, 8'h01);
    end

    // R5 back-to-back frames then stop
    peerByte = 8'h5A; peerBit = 0; fc0 = frameCnt;
    wrReg(2'd1, 8'hC3); rdReg(2'd3, s); wrReg(2'd3, 8'h06);
    s = '0;
    for (int i = 0; i < 20 && !s[0]; i++) rdReg(2'd3, s);
    stopFrame = fc0 + 2; maxHigh = 0; highRun = 0; measure = 1'b1;
    wrReg(2'd1, 8'h18); rdReg(2'd3, s); wrReg(2'd3, 8'h06);
    waitRxFull("R5 first frame");
    chk("R5 first tx byte", lastTx, 8'hC3);
    wrReg(2'd3, 8'h05);
    waitRxFull("R5 second frame");
    chk("R5 second tx byte", lastTx, 8'h18);
    rdReg(2'd2, d); chk("R5 second rx byte", d, 8'h5A);
    chk("R5 no idle between frames", maxHigh, HALF);
    wrReg(2'd3, 8'h05);
    idleClocks(40);
    chk("R5 stops without data", frameCnt, fc0 + 2);
    chk("R5 serClk idle high", serClk, 1);

    // R9 transfer engine strobes
    peerByte = 8'h3C; peerBit = 0;
    @(negedge clk); dmaTxWr = 1'b1; dmaTxData = 8'h96;
    @(negedge clk); dmaTxWr = 1'b0;
    waitRxFull("R9 frame after engine write");
    chk("R9 engine tx byte", lastTx, 8'h96);
    chk("R9 engine rx data", dmaRxData, 8'h3C);
    @(negedge clk); dmaRxRd = 1'b1;
    @(negedge clk); dmaRxRd = 1'b0;
    rdReg(2'd3, s); chk("R9 engine read clears rxFull", s, 8'h01);

    // R10 disabling aborts a frame
    wrReg(2'd1, 8'h00); rdReg(2'd3, s); wrReg(2'd3, 8'h06);
    idleClocks(10);
    chk("R10 frame running", serClk === 1'b1 && txd === 1'b1, 0);
    wrReg(2'd0, 8'h00);
    chk("R10 serClk high after disable", serClk, 1);
    chk("R10 txd high after disable", txd, 1);
    idleClocks(20);
    chk("R10 stays idle", serClk, 1);
    peerBit = 0;

    // R6 R7 R8 overrun in receive-only mode
    peerByte = 8'h71; fc0 = frameCnt;
    wrReg(2'd0, 8'h02);
    waitRxFull("R6 first rx-only frame");
    rdReg(2'd2, d); chk("R6 first byte", d, 8'h71);
    peerByte = 8'h2B;
    idleClocks(60);
    wrReg(2'd3, 8'h03);
    rdReg(2'd3, s); chk("R8 unarmed write keeps overrun", s, 8'h07);
    rdReg(2'd2, d); chk("R6 data kept on overrun", d, 8'h71);
    fc0 = frameCnt;
    idleClocks(40);
    chk("R7 frozen on overrun", frameCnt, fc0);
    @(negedge clk); dmaRxRd = 1'b1;
    @(negedge clk); dmaRxRd = 1'b0;
    idleClocks(40);
    chk("R7 still frozen with rxFull clear", frameCnt, fc0);
    chk("R7 serClk high", serClk, 1);
    rdReg(2'd3, s); chk("R8 status before clear", s, 8'h05);
    peerBit = 0;
    wrReg(2'd3, 8'h03);
    waitRxFull("R7 resumes after clear");
    rdReg(2'd2, d); chk("R6 new byte after resume", d, 8'h2B);
    wrReg(2'd0, 8'h00);
    chk("R10 idle at end", serClk, 1);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule